// File: doc/BRIEF.md
# Blocked Complex Matrix-Multiply Engine

This engine computes one horizontal slice of a complex matrix product, C = A x B. The slice has ROWS rows of C and NCOLS columns. A tile of A with ROWS rows and KDIM columns is written into internal registers while the engine is idle, and it stays fixed for the whole job. After a start pulse, the engine accepts B from a FIFO-style valid/ready port, two complex values per 64-bit beat. B arrives row after row, left to right.

Each beat is broadcast to 2*ROWS complex multiply-accumulate lanes. Lane (r, s) multiplies A[r][k] by the beat's element s. It then adds the product into a per-lane RAM word that belongs to row r and to that element's column. The read, multiply, add and write steps form a four-step pipeline. A bypass from the write step lets a C entry be updated again before its previous update has reached the RAM.

Once every k has been folded in, the pipeline drains. The slice then leaves on a valid/ready output stream, saturated to 16 bits per component. A one-cycle done pulse follows the last accepted word.

Top module: `cplx_tile_mm`

## Requirements
- R1: After reset, in_ready, out_valid and done are all low.
- R2: A complex value is 32 bits: the signed real part is in bits [31:16] and the signed imaginary part is in bits [15:0]. In a 64-bit input beat, bits [31:0] hold the even column j and bits [63:32] hold column j+1.
- R3: Each result equals C[r][j] = sum over k of A[r][k]*B[k][j], using complex arithmetic. The sum is accumulated without loss before saturation.
- R4: After start, in_ready is high only while B is being accepted. B arrives as KDIM*NCOLS/2 beats: k ascending, and within each k the column pairs ascending. in_ready and out_valid are never high together.
- R5: The result stream has ROWS*NCOLS/2 words in row-major order, with rows ascending and then column pairs ascending. Bits [31:0] of each word hold the even column and bits [63:32] hold the odd column, both in the R2 format.
- R6: A component sum above 32767 is output as 32767 (0x7FFF). A component sum below -32768 is output as -32768 (0x8000).
- R7: Each job starts from empty sums. Nothing from an earlier job leaks into the next one.
- R8: Gaps in in_valid stall the engine without dropping or repeating any B value.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R10: done is a single-cycle pulse. It comes in the cycle after the clock edge that accepts the last result word, and it is the only done pulse of the job.
- R11: Writes to the A tile and start pulses are ignored while a job is running. They neither change the results nor queue a second job.
- R12: Beats with no gaps, which update the same C entry on nearby cycles, give the same results as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_we | input | 1 | Write strobe for the A tile (idle only) |
| a_row | input | RW | Row of the A element to write |
| a_col | input | KW | Column of the A element to write |
| a_data | input | 32 | A element in the R2 format |
| start | input | 1 | Begin a job (idle only) |
| done | output | 1 | One-cycle pulse after the last result is accepted |
| in_valid | input | 1 | B beat is valid |
| in_data | input | 64 | Two B values |
| in_ready | output | 1 | Engine accepts a B beat |
| out_valid | output | 1 | Result word is valid |
| out_data | output | 64 | Two saturated C values |
| out_ready | input | 1 | Consumer accepts the result word |

## Verification
Timing of the block's results:
- in_ready rises in the cycle after the edge that samples start.
- A B beat reaches the RAM three edges after its acceptance.
- The first result word is loaded once the three pipeline stages hold no beat.
- done is set by the edge that accepts the last word.

The bench changes inputs and decides every handshake at the falling edge. A handshake seen there takes effect at the next rising edge, so each check samples the value that edge will consume. done and any held output word are examined at the following falling edge. The bench's reference product is built only from the A and B values it sent.

// File: rtl/cplx_tile_mm.sv
module cplx_tile_mm #(
  parameter int ROWS  = 16,
  parameter int KDIM  = 4,
  parameter int NCOLS = 4,
  parameter int ACC_W = 40,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int KW = (KDIM > 1) ? $clog2(KDIM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [RW-1:0] a_row,
  input  logic [KW-1:0] a_col,
  input  logic [31:0]   a_data,
  input  logic          start,
  output logic          done,
  input  logic          in_valid,
  input  logic [63:0]   in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [63:0]   out_data,
  input  logic          out_ready
);
  localparam int DEPTH = NCOLS / 2;
  localparam int LANES = 2 * ROWS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TOT   = ROWS * DEPTH;
  localparam int OW    = $clog2(TOT + 1);

  typedef enum logic [1:0] {S_IDLE, S_FEED, S_DRAIN, S_EMIT} st_t;
  st_t st;

  logic [31:0] a_tile [ROWS][KDIM];
  logic [KW-1:0] kc, k1;
  logic [AW-1:0] jc, a1, a2, a3, ocol;
  logic [RW-1:0] orow;
  logic [OW-1:0] ocnt;
  logic v1, v2, v3, f1, f2;
  logic [63:0] bw1;
  logic [2*ACC_W-1:0] lane_rd [LANES];

  assign in_ready = (st == S_FEED);
  wire take    = in_valid && in_ready;
  wire last_k  = (kc == KW'(KDIM - 1));
  wire last_j  = (jc == AW'(DEPTH - 1));
  wire hit_in  = v3 && (a3 == jc);
  wire hit1    = v3 && (a3 == a1);
  wire hit2    = v3 && (a3 == a2);

  function automatic logic [15:0] sat16(input logic signed [ACC_W-1:0] x);
    if (x > ACC_W'(32767))       return 16'h7fff;
    else if (x < ACC_W'(-32768)) return 16'h8000;
    else                         return x[15:0];
  endfunction

  function automatic logic [31:0] pack_c(input logic [2*ACC_W-1:0] acc);
    return {sat16(acc[2*ACC_W-1:ACC_W]), sat16(acc[ACC_W-1:0])};
  endfunction

  always_ff @(posedge clk)
    if (st == S_IDLE && a_we) a_tile[a_row][a_col] <= a_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      kc <= '0;
      jc <= '0;
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      done <= 1'b0;
      out_valid <= 1'b0;
      out_data <= '0;
      orow <= '0;
      ocol <= '0;
      ocnt <= '0;
    end else begin
      done <= 1'b0;
      v1 <= take;
      v2 <= v1;
      v3 <= v2;
      case (st)
        S_IDLE: if (start) begin
          st <= S_FEED;
          kc <= '0;
          jc <= '0;
        end
        S_FEED: if (take) begin
          if (last_j) begin
            jc <= '0;
            kc <= kc + 1'b1;
            if (last_k) st <= S_DRAIN;
          end else begin
            jc <= jc + 1'b1;
          end
        end
        S_DRAIN: if (!v1 && !v2 && !v3) begin
          st <= S_EMIT;
          orow <= '0;
          ocol <= '0;
          ocnt <= '0;
        end
        S_EMIT: if (!out_valid || out_ready) begin
          if (ocnt != OW'(TOT)) begin
            out_data <= {pack_c(lane_rd[2*int'(orow)+1]), pack_c(lane_rd[2*int'(orow)])};
            out_valid <= 1'b1;
            ocnt <= ocnt + 1'b1;
            if (ocol == AW'(DEPTH - 1)) begin
              ocol <= '0;
              orow <= orow + 1'b1;
            end else begin
              ocol <= ocol + 1'b1;
            end
          end else if (out_valid) begin
            out_valid <= 1'b0;
            done <= 1'b1;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    a1 <= jc;
    k1 <= kc;
    f1 <= (kc == '0);
    bw1 <= in_data;
    a2 <= a1;
    f2 <= f1;
    a3 <= a2;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int R = l / 2;
    localparam int S = l % 2;
    logic [2*ACC_W-1:0] mem [DEPTH];
    logic [2*ACC_W-1:0] rd1, old2, pr2, s3q, oldsel;
    logic [31:0] a_el, b_el;
    logic signed [15:0] ar, ai, br, bi;
    logic signed [31:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [ACC_W-1:0] p_re, p_im, s_re, s_im;

    assign a_el = a_tile[R][k1];
    assign b_el = bw1[S*32 +: 32];
    assign ar = a_el[31:16];
    assign ai = a_el[15:0];
    assign br = b_el[31:16];
    assign bi = b_el[15:0];
    assign m_rr = ar * br;
    assign m_ii = ai * bi;
    assign m_ri = ar * bi;
    assign m_ir = ai * br;
    assign p_re = ACC_W'(m_rr) - ACC_W'(m_ii);
    assign p_im = ACC_W'(m_ri) + ACC_W'(m_ir);
    assign oldsel = hit2 ? s3q : old2;
    assign s_re = oldsel[2*ACC_W-1:ACC_W] + pr2[2*ACC_W-1:ACC_W];
    assign s_im = oldsel[ACC_W-1:0] + pr2[ACC_W-1:0];
    assign lane_rd[l] = mem[ocol];

    always_ff @(posedge clk) begin
      if (v3) mem[a3] <= s3q;
      rd1  <= hit_in ? s3q : mem[jc];
      old2 <= hit1 ? s3q : rd1;
      pr2  <= {p_re, p_im};
      s3q  <= f2 ? pr2 : {s_re, s_im};
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_hs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
  p_emit_drained_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(v1 || v2 || v3));
endmodule

// File: tb/cplx_tile_mm_bench.sv
module cplx_tile_mm_bench;
  localparam int ROWS = 16, KDIM = 4, NCOLS = 4;
  localparam int DEPTH = NCOLS / 2, TOT = ROWS * DEPTH, BEATS = KDIM * DEPTH;
  localparam int RW = $clog2(ROWS), KW = $clog2(KDIM);

  logic clk = 0, rst_n = 0;
  logic a_we = 0, start = 0, in_valid = 0, out_ready = 0;
  logic [RW-1:0] a_row = '0;
  logic [KW-1:0] a_col = '0;
  logic [31:0] a_data = '0;
  logic [63:0] in_data = '0;
  logic done, in_ready, out_valid;
  logic [63:0] out_data;
  int n_tests = 0, n_fail = 0;
  logic [31:0] am [ROWS][KDIM];
  logic [31:0] bm [KDIM][NCOLS];

  always #5 clk = ~clk;

  cplx_tile_mm #(.ROWS(ROWS), .KDIM(KDIM), .NCOLS(NCOLS)) u_cplx_tile_mm (
    .clk(clk), .rst_n(rst_n), .a_we(a_we), .a_row(a_row), .a_col(a_col),
    .a_data(a_data), .start(start), .done(done), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready));

  function automatic logic [15:0] sat(input longint v);
    if (v > 32767) return 16'h7fff;
    if (v < -32768) return 16'h8000;
    return 16'(v);
  endfunction

  function automatic logic [31:0] cref(input int r, input int j);
    longint re = 0, im = 0;
    for (int k = 0; k < KDIM; k++) begin
      longint ar = longint'($signed(am[r][k][31:16]));
      longint ai = longint'($signed(am[r][k][15:0]));
      longint br = longint'($signed(bm[k][j][31:16]));
      longint bi = longint'($signed(bm[k][j][15:0]));
      re += ar * br - ai * bi;
      im += ar * bi + ai * br;
    end
    return {sat(re), sat(im)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input int mode);
    logic [15:0] ext [3] = '{16'h7fff, 16'h8000, 16'h8001};
    if (mode == 0) return {16'($signed($urandom_range(400)) - 200), 16'($signed($urandom_range(400)) - 200)};
    if (mode == 1) return $urandom;
    return {ext[$urandom_range(2)], ext[$urandom_range(2)]};
  endfunction

  task automatic fill(input int mode);
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < KDIM; k++) am[r][k] = pick(mode);
    for (int k = 0; k < KDIM; k++)
      for (int j = 0; j < NCOLS; j++) bm[k][j] = pick(mode);
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < KDIM; k++) begin
        @(negedge clk);
        a_we = 1; a_row = RW'(r); a_col = KW'(k); a_data = am[r][k];
      end
    @(negedge clk);
    a_we = 0;
  endtask

  task automatic run_job(input int gap, input int stall, input bit poke, input string req);
    int bi = 0, oi = 0, cyc = 0, dones = 0;
    bit held = 0, fin = 0, rdy_chk = 0;
    logic [63:0] hd = '0, ex;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!fin && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      a_we = 0; start = 0;
      if (held) check(out_valid && out_data == hd, "R9 hold", out_data, hd);
      if (done) begin
        dones++;
        check(oi == TOT, "R10 done after last word", 64'(oi), 64'(TOT));
        fin = 1;
      end
      if (bi == BEATS && !rdy_chk && !in_ready) rdy_chk = 1;
      if (in_ready && bi < BEATS && $urandom_range(99) >= gap) begin
        in_valid = 1;
        in_data = {bm[bi / DEPTH][2 * (bi % DEPTH) + 1], bm[bi / DEPTH][2 * (bi % DEPTH)]};
        bi++;
      end else in_valid = 0;
      if (poke && bi == 3) begin
        a_we = 1; a_row = '0; a_col = '0; a_data = ~am[0][0];
        start = 1;
      end
      out_ready = ($urandom_range(99) >= stall);
      if (out_valid && out_ready) begin
        ex = {cref(oi / DEPTH, 2 * (oi % DEPTH) + 1), cref(oi / DEPTH, 2 * (oi % DEPTH))};
        check(out_data == ex, req, out_data, ex);
        oi++;
        held = 0;
      end else begin
        held = out_valid;
        hd = out_data;
      end
    end
    in_valid = 0; out_ready = 0; a_we = 0; start = 0;
    check(fin, "R10 job finished", 64'(cyc), 64'(0));
    check(bi == BEATS, "R4 beat count", 64'(bi), 64'(BEATS));
    check(rdy_chk, "R4 in_ready drops after last beat", 64'(rdy_chk), 64'(1));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done) dones++;
      check(!in_ready && !out_valid, "R11 no second job", {62'd0, in_ready, out_valid}, 64'd0);
    end
    check(dones == 1, "R10 single done pulse", 64'(dones), 64'd1);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!in_ready && !out_valid && !done, "R1 reset state", {61'd0, in_ready, out_valid, done}, 64'd0);
    fill(0); run_job(0, 0, 0, "R12 R2 R5 back-to-back");
    fill(0); run_job(40, 30, 1, "R11 R8 busy poke");
    fill(1); run_job(70, 60, 0, "R3 R7 R8 full range");
    fill(2); run_job(20, 50, 0, "R6 saturation");
    fill(0); run_job(0, 80, 0, "R7 R9 new slice");
    fill(1); run_job(10, 0, 0, "R3 R12 mixed");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule